// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits on the write path of a two-bank flash array and turns bus write cycles (address plus data byte) into commands. It recognises a two-cycle unlock prefix and then dispatches to a power-saving enable or an autoselect entry. It also runs a repeatable sector lock/unlock sequence and a reset command that can be written at any point. It keeps one lock bit per sector, a sticky power-saving flag and an autoselect flag per bank. From these and from the program/erase status inputs it reports a registered mode for each bank.

The per-sector lock bits are combined with the write-protect pin and the two programming-voltage level inputs into one effective protection bit per sector. While a bank is in autoselect, reads at addresses in that bank return identification and protection data on a separate read port. The program and erase algorithms live outside this block. They show up only as busy, suspend and timeout status inputs, and the block signals them through a one-cycle abort pulse when a reset is accepted during a timed-out operation.

The default build has a 16-bit address. The sector number is `addr[15:12]` (16 sectors), the bank is `addr[15]`, and command addresses are compared on the sector offset `addr[11:0]`. Every output changes on the clock edge that samples the write or the status input that causes the change.

Top module: `flash_cmd_decoder`

## Requirements
- R1: During and after a synchronous reset (`rst` high), every sector lock bit is set, `sector_prot` is all ones, `ps_on` is 0, every bank mode is read (0), and `asel_valid`, `asel_data` and `bank_abort` are 0.
- R2: The writes AAh at offset 555h, 55h at offset 2AAh and 70h at offset 555h set `ps_on` one edge after the third write. It then stays set through any further writes until `rst`.
- R3: The writes 60h, 60h (any address) and then 60h at a sector address set that sector's lock bit to the inverse of address bit 6. Bit 6 = 1 unlocks the sector and bit 6 = 0 locks it.
- R4: After the third 60h cycle, each further 60h write locks or unlocks the sector it addresses without a new prefix. A write of F0h ends the sequence, after which a single 60h write changes no lock bit.
- R5: A write that does not continue the current sequence returns the decoder to idle, with no change to locks, power saving or bank modes, and is not taken as the start of a new sequence.
- R6: The effective protection of sector s is computed in priority order. If `vpp_low` = 1, it is 1. Otherwise, if `wp_n` = 0 and s is 0 or 15, it is 1. Otherwise, if `vpp_high` = 1, it is 0. Otherwise, it is the lock bit.
- R7: AAh at 555h, 55h at 2AAh and then 90h at any address puts the addressed bank into autoselect. This happens only when neither that bank nor any other bank is busy (program or erase busy input high). Otherwise the command has no effect.
- R8: A write of F0h at any address returns the decoder to idle, even partway through a sequence, and clears autoselect of the addressed bank when that bank is not busy. The bank then reports erase-suspend-read if its suspend input is high, and read otherwise.
- R9: While the addressed bank is busy, F0h is ignored unless that bank's `op_timeout` is high. In that case `bank_abort` for the bank pulses for one cycle.
- R10: `bank_mode` for each bank (3 bits, bank b at bits 3b+2:3b) is chosen in priority order: program busy gives 3, erase busy gives 4, autoselect gives 1, erase suspended gives 2, and otherwise the mode is read, 0.
- R11: One edge after `rd_addr` is applied, `asel_valid` shows whether the bank of `rd_addr` is in autoselect. When it is set, `asel_data` is 01h for offset 0, 5Ah for offset 1, the effective protection bit of the addressed sector for offset 2, and 0 for any other offset. When it is clear, `asel_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| wr_en | input | 1 | Bus write cycle strobe |
| wr_addr | input | 16 | Write address |
| wr_data | input | 8 | Write data / command byte |
| rd_addr | input | 16 | Read address for autoselect data |
| prog_busy | input | 2 | Per-bank program in progress |
| erase_busy | input | 2 | Per-bank erase in progress |
| erase_susp | input | 2 | Per-bank erase suspended |
| op_timeout | input | 2 | Per-bank operation timeout flag |
| wp_n | input | 1 | Write protect, active low, guards boot sectors |
| vpp_low | input | 1 | Programming voltage at low level |
| vpp_high | input | 1 | Programming voltage at high level |
| ps_on | output | 1 | Power-saving mode enabled |
| bank_mode | output | 6 | Mode code per bank, 3 bits each |
| bank_abort | output | 2 | One-cycle abort request per bank |
| sector_prot | output | 16 | Effective protection per sector |
| asel_valid | output | 1 | Read address bank is in autoselect |
| asel_data | output | 8 | Autoselect read data |

## Verification
The bench targets sequences broken at each position, resets written mid-prefix, and lone 60h writes after the lock sequence has closed. A decoder that failed to return to idle on a mismatch would enable power saving or change a lock on a later stray byte. One that reinterpreted the mismatching byte would start a new sequence from it. It also runs autoselect attempts while either bank is busy and resets with and without the timeout flag, where a wrong design would enter autoselect or abort an operation that must run on. Finally it checks every step of the protection priority and reads autoselect data from the other bank, where swapped precedence or a missing bank check shows up directly on `sector_prot` and `asel_data`.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [2:0] {
    MODE_READ  = 3'd0,
    MODE_ASEL  = 3'd1,
    MODE_ESR   = 3'd2,
    MODE_PROG  = 3'd3,
    MODE_ERASE = 3'd4
  } bank_mode_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_UNL1,
    SQ_UNL2,
    SQ_LK1,
    SQ_LK2,
    SQ_LKRUN
  } seq_state_e;

  localparam logic [7:0] CMD_UNL1  = 8'hAA;
  localparam logic [7:0] CMD_UNL2  = 8'h55;
  localparam logic [7:0] CMD_PS    = 8'h70;
  localparam logic [7:0] CMD_ASEL  = 8'h90;
  localparam logic [7:0] CMD_LOCK  = 8'h60;
  localparam logic [7:0] CMD_RESET = 8'hF0;

  localparam int unsigned UNL_ADDR1 = 32'h555;
  localparam int unsigned UNL_ADDR2 = 32'h2AA;

endpackage

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int OFS_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en_i,
  input  logic [OFS_W-1:0] wr_ofs_i,
  input  logic [7:0]       wr_data_i,
  output logic             cmd_ps_o,
  output logic             cmd_asel_o,
  output logic             cmd_lock_o,
  output logic             cmd_reset_o
);

  localparam logic [OFS_W-1:0] A1 = OFS_W'(UNL_ADDR1);
  localparam logic [OFS_W-1:0] A2 = OFS_W'(UNL_ADDR2);

  seq_state_e state_q, state_nxt;

  always_comb begin
    state_nxt   = state_q;
    cmd_ps_o    = 1'b0;
    cmd_asel_o  = 1'b0;
    cmd_lock_o  = 1'b0;
    cmd_reset_o = 1'b0;
    if (wr_en_i) begin
      if (wr_data_i == CMD_RESET) begin
        cmd_reset_o = 1'b1;
        state_nxt   = SQ_IDLE;
      end else begin
        state_nxt = SQ_IDLE;
        case (state_q)
          SQ_IDLE: begin
            if (wr_data_i == CMD_UNL1 && wr_ofs_i == A1) state_nxt = SQ_UNL1;
            else if (wr_data_i == CMD_LOCK)              state_nxt = SQ_LK1;
          end
          SQ_UNL1: begin
            if (wr_data_i == CMD_UNL2 && wr_ofs_i == A2) state_nxt = SQ_UNL2;
          end
          SQ_UNL2: begin
            if (wr_data_i == CMD_PS && wr_ofs_i == A1) cmd_ps_o   = 1'b1;
            else if (wr_data_i == CMD_ASEL)            cmd_asel_o = 1'b1;
          end
          SQ_LK1: begin
            if (wr_data_i == CMD_LOCK) state_nxt = SQ_LK2;
          end
          SQ_LK2, SQ_LKRUN: begin
            if (wr_data_i == CMD_LOCK) begin
              cmd_lock_o = 1'b1;
              state_nxt  = SQ_LKRUN;
            end
          end
          default: state_nxt = SQ_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= SQ_IDLE;
    else     state_q <= state_nxt;
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmd_ps_o, cmd_asel_o, cmd_lock_o, cmd_reset_o})); // R5
  AST_RESET_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && wr_data_i == CMD_RESET) |=> (state_q == SQ_IDLE)); // R8

endmodule

// File: rtl/flash_bank_ctrl.sv
module flash_bank_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = $clog2(NUM_BANKS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cmd_asel_i,
  input  logic                   cmd_reset_i,
  input  logic [BANK_W-1:0]      wr_bank_i,
  input  logic [NUM_BANKS-1:0]   prog_busy_i,
  input  logic [NUM_BANKS-1:0]   erase_busy_i,
  input  logic [NUM_BANKS-1:0]   erase_susp_i,
  input  logic [NUM_BANKS-1:0]   timeout_i,
  output logic [NUM_BANKS-1:0]   asel_nxt_o,
  output logic [NUM_BANKS*3-1:0] mode_o,
  output logic [NUM_BANKS-1:0]   abort_o
);

  logic [NUM_BANKS-1:0] busy, oth_busy, asel_q, abort_nxt;

  assign busy = prog_busy_i | erase_busy_i;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic       hit;
    bank_mode_e mode_nxt;

    assign oth_busy[b] = |(busy & ~(NUM_BANKS'(1) << b));
    assign hit         = (wr_bank_i == BANK_W'(b));

    always_comb begin
      asel_nxt_o[b] = asel_q[b];
      abort_nxt[b]  = 1'b0;
      if (cmd_reset_i && hit) begin
        if (!busy[b]) begin
          asel_nxt_o[b] = 1'b0;
        end else if (timeout_i[b]) begin
          asel_nxt_o[b] = 1'b0;
          abort_nxt[b]  = 1'b1;
        end
      end
      if (cmd_asel_i && hit && !busy[b] && !oth_busy[b]) asel_nxt_o[b] = 1'b1;
    end

    always_comb begin
      if (prog_busy_i[b])       mode_nxt = MODE_PROG;
      else if (erase_busy_i[b]) mode_nxt = MODE_ERASE;
      else if (asel_nxt_o[b])   mode_nxt = MODE_ASEL;
      else if (erase_susp_i[b]) mode_nxt = MODE_ESR;
      else                      mode_nxt = MODE_READ;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        asel_q[b]       <= 1'b0;
        abort_o[b]      <= 1'b0;
        mode_o[b*3 +: 3] <= MODE_READ;
      end else begin
        asel_q[b]       <= asel_nxt_o[b];
        abort_o[b]      <= abort_nxt[b];
        mode_o[b*3 +: 3] <= mode_nxt;
      end
    end

    AST_ASEL_ENTRY_GUARD: assert property (@(posedge clk) disable iff (rst)
      $rose(asel_q[b]) |-> $past(!busy[b] && !oth_busy[b])); // R7
    AST_ABORT_ONLY_TIMEOUT: assert property (@(posedge clk) disable iff (rst)
      abort_o[b] |-> $past(busy[b] && timeout_i[b])); // R9
    AST_PROG_WINS: assert property (@(posedge clk) disable iff (rst)
      prog_busy_i[b] |=> (mode_o[b*3 +: 3] == MODE_PROG)); // R10
  end

endmodule

// File: rtl/flash_sector_prot.sv
module flash_sector_prot #(
  parameter int NUM_SECTORS = 16,
  parameter int SEC_W       = $clog2(NUM_SECTORS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cmd_lock_i,
  input  logic                   lock_set_i,
  input  logic [SEC_W-1:0]       wr_sector_i,
  input  logic                   wp_n_i,
  input  logic                   vpp_low_i,
  input  logic                   vpp_high_i,
  input  logic [SEC_W-1:0]       rd_sector_i,
  output logic                   rd_prot_o,
  output logic [NUM_SECTORS-1:0] prot_o
);

  logic [NUM_SECTORS-1:0] lock_q, lock_nxt, prot_nxt;

  always_comb begin
    lock_nxt = lock_q;
    if (cmd_lock_i) lock_nxt[wr_sector_i] = lock_set_i;
  end

  for (genvar s = 0; s < NUM_SECTORS; s++) begin : g_sec
    localparam bit BOOT = (s == 0) || (s == NUM_SECTORS - 1);
    assign prot_nxt[s] = vpp_low_i
                       | (!wp_n_i && BOOT)
                       | (!vpp_high_i && lock_nxt[s]);
  end

  assign rd_prot_o = prot_nxt[rd_sector_i];

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q <= '1;
      prot_o <= '1;
    end else begin
      lock_q <= lock_nxt;
      prot_o <= prot_nxt;
    end
  end

  AST_VPP_LOW_ALL: assert property (@(posedge clk) disable iff (rst)
    vpp_low_i |=> (&prot_o)); // R6
  AST_LOCK_ONLY_ON_CMD: assert property (@(posedge clk) disable iff (rst)
    !cmd_lock_i |=> $stable(lock_q)); // R5

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int          ADDR_W      = 16,
  parameter int          NUM_SECTORS = 16,
  parameter int          NUM_BANKS   = 2,
  parameter int          LOCK_BIT    = 6,
  parameter logic [7:0]  MFR_CODE    = 8'h01,
  parameter logic [7:0]  DEV_CODE    = 8'h5A
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [7:0]               wr_data,
  input  logic [ADDR_W-1:0]        rd_addr,
  input  logic [NUM_BANKS-1:0]     prog_busy,
  input  logic [NUM_BANKS-1:0]     erase_busy,
  input  logic [NUM_BANKS-1:0]     erase_susp,
  input  logic [NUM_BANKS-1:0]     op_timeout,
  input  logic                     wp_n,
  input  logic                     vpp_low,
  input  logic                     vpp_high,
  output logic                     ps_on,
  output logic [NUM_BANKS*3-1:0]   bank_mode,
  output logic [NUM_BANKS-1:0]     bank_abort,
  output logic [NUM_SECTORS-1:0]   sector_prot,
  output logic                     asel_valid,
  output logic [7:0]               asel_data
);

  localparam int SEC_W   = $clog2(NUM_SECTORS);
  localparam int BANK_W  = $clog2(NUM_BANKS);
  localparam int OFS_W   = ADDR_W - SEC_W;

  logic                 cmd_ps, cmd_asel, cmd_lock, cmd_reset, rd_prot;
  logic [NUM_BANKS-1:0] asel_nxt;
  logic [SEC_W-1:0]     wr_sector, rd_sector;
  logic [BANK_W-1:0]    wr_bank, rd_bank;
  logic [OFS_W-1:0]     rd_ofs;
  logic [7:0]           rd_word;

  assign wr_sector = wr_addr[ADDR_W-1 -: SEC_W];
  assign rd_sector = rd_addr[ADDR_W-1 -: SEC_W];
  assign wr_bank   = wr_sector[SEC_W-1 -: BANK_W];
  assign rd_bank   = rd_sector[SEC_W-1 -: BANK_W];
  assign rd_ofs    = rd_addr[OFS_W-1:0];

  flash_cmd_seq #(.OFS_W(OFS_W)) i_seq (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_ofs_i(wr_addr[OFS_W-1:0]),
    .wr_data_i(wr_data), .cmd_ps_o(cmd_ps), .cmd_asel_o(cmd_asel),
    .cmd_lock_o(cmd_lock), .cmd_reset_o(cmd_reset)
  );

  flash_bank_ctrl #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) i_banks (
    .clk(clk), .rst(rst), .cmd_asel_i(cmd_asel), .cmd_reset_i(cmd_reset),
    .wr_bank_i(wr_bank), .prog_busy_i(prog_busy), .erase_busy_i(erase_busy),
    .erase_susp_i(erase_susp), .timeout_i(op_timeout), .asel_nxt_o(asel_nxt),
    .mode_o(bank_mode), .abort_o(bank_abort)
  );

  flash_sector_prot #(.NUM_SECTORS(NUM_SECTORS), .SEC_W(SEC_W)) i_prot (
    .clk(clk), .rst(rst), .cmd_lock_i(cmd_lock), .lock_set_i(!wr_addr[LOCK_BIT]),
    .wr_sector_i(wr_sector), .wp_n_i(wp_n), .vpp_low_i(vpp_low),
    .vpp_high_i(vpp_high), .rd_sector_i(rd_sector), .rd_prot_o(rd_prot),
    .prot_o(sector_prot)
  );

  always_comb begin
    if (rd_ofs == OFS_W'(0))      rd_word = MFR_CODE;
    else if (rd_ofs == OFS_W'(1)) rd_word = DEV_CODE;
    else if (rd_ofs == OFS_W'(2)) rd_word = {7'd0, rd_prot};
    else                          rd_word = 8'd0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ps_on      <= 1'b0;
      asel_valid <= 1'b0;
      asel_data  <= 8'd0;
    end else begin
      ps_on      <= ps_on | cmd_ps;
      asel_valid <= asel_nxt[rd_bank];
      asel_data  <= asel_nxt[rd_bank] ? rd_word : 8'd0;
    end
  end

  AST_PS_STICKY: assert property (@(posedge clk) disable iff (rst)
    ps_on |=> ps_on); // R2
  AST_NO_DATA_OUTSIDE_ASEL: assert property (@(posedge clk) disable iff (rst)
    !asel_valid |-> (asel_data == 8'd0)); // R11

endmodule

// File: tb/test_flash_cmd_decoder.sv
module test_flash_cmd_decoder;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [15:0] rd_addr = '0;
  logic [1:0]  prog_busy = '0, erase_busy = '0, erase_susp = '0, op_timeout = '0;
  logic        wp_n = 1'b1, vpp_low = 1'b0, vpp_high = 1'b0;
  logic        ps_on, asel_valid;
  logic [5:0]  bank_mode;
  logic [1:0]  bank_abort;
  logic [15:0] sector_prot;
  logic [7:0]  asel_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  flash_cmd_decoder i_flash_cmd_decoder (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .prog_busy(prog_busy), .erase_busy(erase_busy),
    .erase_susp(erase_susp), .op_timeout(op_timeout), .wp_n(wp_n),
    .vpp_low(vpp_low), .vpp_high(vpp_high), .ps_on(ps_on), .bank_mode(bank_mode),
    .bank_abort(bank_abort), .sector_prot(sector_prot), .asel_valid(asel_valid),
    .asel_data(asel_data)
  );

  // Behavioural reference model
  int          m_state;
  bit [15:0]   m_lock, m_prot;
  bit [1:0]    m_asel, m_abort;
  bit          m_ps, m_aval;
  bit [2:0]    m_mode [2];
  bit [7:0]    m_adata;

  function automatic bit busy_of(int b);
    return prog_busy[b] | erase_busy[b];
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_state = 0; m_lock = '1; m_prot = '1; m_asel = 0; m_abort = 0;
      m_ps = 0; m_aval = 0; m_adata = 0; m_mode[0] = 0; m_mode[1] = 0;
    end else begin
      int bk, nx;
      m_abort = 0;
      bk = wr_addr[15];
      if (wr_en) begin
        if (wr_data == 8'hF0) begin
          if (!busy_of(bk)) m_asel[bk] = 0;
          else if (op_timeout[bk]) begin m_asel[bk] = 0; m_abort[bk] = 1; end
          m_state = 0;
        end else begin
          nx = 0;
          case (m_state)
            0: if (wr_data == 8'hAA && wr_addr[11:0] == 12'h555) nx = 1;
               else if (wr_data == 8'h60) nx = 3;
            1: if (wr_data == 8'h55 && wr_addr[11:0] == 12'h2AA) nx = 2;
            2: if (wr_data == 8'h70 && wr_addr[11:0] == 12'h555) m_ps = 1;
               else if (wr_data == 8'h90 && !busy_of(bk) && !busy_of(1 - bk)) m_asel[bk] = 1;
            3: if (wr_data == 8'h60) nx = 4;
            4, 5: if (wr_data == 8'h60) begin m_lock[wr_addr[15:12]] = !wr_addr[6]; nx = 5; end
            default: nx = 0;
          endcase
          m_state = nx;
        end
      end
      for (int b = 0; b < 2; b++)
        m_mode[b] = prog_busy[b] ? 3'd3 : erase_busy[b] ? 3'd4 : m_asel[b] ? 3'd1 :
                    erase_susp[b] ? 3'd2 : 3'd0;
      for (int s = 0; s < 16; s++)
        m_prot[s] = vpp_low ? 1'b1 : (!wp_n && (s == 0 || s == 15)) ? 1'b1 :
                    vpp_high ? 1'b0 : m_lock[s];
      m_aval = m_asel[rd_addr[15]];
      if (!m_aval) m_adata = 0;
      else if (rd_addr[11:0] == 0) m_adata = 8'h01;
      else if (rd_addr[11:0] == 1) m_adata = 8'h5A;
      else if (rd_addr[11:0] == 2) m_adata = {7'd0, m_prot[rd_addr[15:12]]};
      else m_adata = 0;
    end
  end

  task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    cmp("R6 sector_prot vs model", 32'(sector_prot), 32'(m_prot));
    cmp("R2 ps_on vs model", 32'(ps_on), 32'(m_ps));
    cmp("R10 bank_mode vs model", 32'(bank_mode), 32'({m_mode[1], m_mode[0]}));
    cmp("R9 bank_abort vs model", 32'(bank_abort), 32'(m_abort));
    cmp("R11 asel_valid vs model", 32'(asel_valid), 32'(m_aval));
    cmp("R11 asel_data vs model", 32'(asel_data), 32'(m_adata));
  endtask

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_all();
    end
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state, checked while reset is still held
    cmp("R1 prot during reset", 32'(sector_prot), 32'hFFFF);
    cmp("R1 ps during reset", 32'(ps_on), 0);
    rst = 0;
    tick();
    cmp("R1 modes after reset", 32'(bank_mode), 0);
    cmp("R1 asel_valid after reset", 32'(asel_valid), 0);

    // R3 / R4 lock sequence
    wr(16'h0000, 8'h60); wr(16'h1234, 8'h60); wr(16'h3040, 8'h60);
    cmp("R3 sector 3 unlocked", 32'(sector_prot[3]), 0);
    wr(16'h5040, 8'h60);
    cmp("R4 sector 5 unlocked without prefix", 32'(sector_prot[5]), 0);
    wr(16'h3000, 8'h60);
    cmp("R3 sector 3 relocked A6 low", 32'(sector_prot[3]), 1);
    wr(16'h0000, 8'hF0);
    wr(16'h7040, 8'h60);
    cmp("R4 lone 60h after exit leaves sector 7 locked", 32'(sector_prot[7]), 1);
    // R5 mismatch in LK1 is not a new prefix
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55); wr(16'h0555, 8'h70);
    cmp("R5 mismatched AAh not taken as prefix", 32'(ps_on), 0);
    // R5 wrong third byte, wrong second address
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55); wr(16'h0555, 8'h12);
    wr(16'h0555, 8'h70);
    cmp("R5 wrong command byte has no effect", 32'(ps_on), 0);
    wr(16'h0555, 8'hAA); wr(16'h0555, 8'h55); wr(16'h0555, 8'h70);
    cmp("R5 wrong unlock address", 32'(ps_on), 0);
    // R8 reset mid-prefix
    wr(16'h0555, 8'hAA); wr(16'h0000, 8'hF0); wr(16'h02AA, 8'h55); wr(16'h0555, 8'h70);
    cmp("R8 reset mid-sequence returns idle", 32'(ps_on), 0);
    // R2 power saving
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55); wr(16'h0555, 8'h70);
    cmp("R2 power saving enabled", 32'(ps_on), 1);
    wr(16'h0000, 8'hF0); wr(16'h4321, 8'h33);
    cmp("R2 power saving sticky", 32'(ps_on), 1);

    // R6 protection priority
    vpp_high = 1; tick();
    cmp("R6 vpp high unlocks all", 32'(sector_prot), 0);
    wp_n = 0; tick();
    cmp("R6 wp low forces boot sectors", 32'(sector_prot), 32'h8001);
    vpp_low = 1; tick();
    cmp("R6 vpp low locks all", 32'(sector_prot), 32'hFFFF);
    vpp_low = 0; vpp_high = 0; tick();
    cmp("R6 lock bits with wp low", 32'(sector_prot), 32'hFFDF);
    wp_n = 1; tick();

    // R7 / R11 autoselect
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55); wr(16'h8000, 8'h90);
    cmp("R7 bank1 enters autoselect", 32'(bank_mode[5:3]), 1);
    cmp("R7 bank0 unaffected", 32'(bank_mode[2:0]), 0);
    rd_addr = 16'h8000; tick();
    cmp("R11 manufacturer code", 32'(asel_data), 32'h01);
    rd_addr = 16'h9001; tick();
    cmp("R11 device code", 32'(asel_data), 32'h5A);
    rd_addr = 16'h8002; tick();
    cmp("R11 protection of locked sector 8", 32'(asel_data), 1);
    rd_addr = 16'h0000; tick();
    cmp("R11 other bank not valid", 32'(asel_valid), 0);
    cmp("R11 other bank data zero", 32'(asel_data), 0);

    // R8 / R10 reset from autoselect into erase-suspend-read
    erase_susp[1] = 1; tick();
    cmp("R10 autoselect outranks suspend", 32'(bank_mode[5:3]), 1);
    wr(16'h8000, 8'hF0);
    cmp("R8 reset returns to erase-suspend-read", 32'(bank_mode[5:3]), 2);
    erase_susp[1] = 0; tick();
    cmp("R10 read mode", 32'(bank_mode[5:3]), 0);

    // R7 / R9 busy handling
    prog_busy[0] = 1; tick();
    cmp("R10 program busy", 32'(bank_mode[2:0]), 3);
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55); wr(16'h8000, 8'h90);
    cmp("R7 blocked while other bank busy", 32'(bank_mode[5:3]), 0);
    wr(16'h0000, 8'hF0);
    cmp("R9 reset ignored while busy", 32'(bank_abort), 0);
    op_timeout[0] = 1;
    wr(16'h0000, 8'hF0);
    cmp("R9 abort pulse with timeout", 32'(bank_abort), 1);
    tick();
    cmp("R9 abort lasts one cycle", 32'(bank_abort), 0);
    prog_busy[0] = 0; op_timeout[0] = 0;
    erase_busy[1] = 1;
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55); wr(16'h8000, 8'h90);
    cmp("R10 erase busy", 32'(bank_mode[5:3]), 4);
    erase_busy[1] = 0; tick();
    cmp("R7 no autoselect entered while busy", 32'(bank_mode[5:3]), 0);

    // R1 hardware reset clears power saving and relocks
    rst = 1; tick(); rst = 0; tick();
    cmp("R1 ps cleared by reset", 32'(ps_on), 0);
    cmp("R1 all sectors locked after reset", 32'(sector_prot), 32'hFFFF);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule